// File: doc/BRIEF.md
# CEC Frame Receiver with Address Acknowledge

This block is the byte-level half of a CEC follower. A bit decoder in front of it reports each sampled data bit as a one-cycle `bit_valid` pulse carrying `bit_val`, and reports each detected start bit on `start_det`. The receiver groups the bits into blocks: eight payload bits, most significant first, then an end-of-message bit, then the acknowledge slot. The first block of a frame is the header. The upper nibble of the header is the initiator and the lower nibble is the destination. Destination 15 is broadcast.

When the header's last payload bit arrives, the destination is compared with a 15-bit own-address mask. The result selects one of four frame modes. A direct frame is acknowledged and delivered. A broadcast frame is delivered, and its slot is pulled low only to reject it. A listen frame is delivered silently. An ignored frame is dropped. For each block, the block asks the line driver to pull the acknowledge slot low through `ack_drive`. Every delivered byte goes to a one-entry buffer with sticky flags that are cleared by writing one.

The state machine has four states. IDLE ignores bits. DATA shifts payload bits. EOM takes the end-of-message bit and delivers the byte. ACK holds the acknowledge decision until the slot bit has been sampled. The transitions are as follows:
- start → DATA from every state.
- DATA → EOM after the eighth bit.
- DATA → IDLE on a header for an ignored destination.
- EOM → ACK on the end-of-message bit.
- ACK → DATA for the next block.
- ACK → IDLE after the final block, after an overrun, or after a missing-acknowledge abort.
- A low `enable` forces IDLE.

Top module: `cec_frame_rx`

## Requirements
- R1: Payload bits are assembled most significant bit first. When the end-of-message bit of a block arrives, the byte appears on `rx_data` and `rx_byte` is set.
- R2: The header destination is header bits 3:0. A destination d below 15 is accepted when `own_mask[d]` is 1. For example, mask 0x0021 accepts addresses 0 and 5.
- R3: In a frame with an accepted destination, `ack_drive` is high during the acknowledge slot of every block, from the cycle after the end-of-message bit until the slot bit is sampled. Every byte of the frame is delivered.
- R4: A broadcast frame (destination 15) is always delivered. `ack_drive` stays low in its slots unless the frame is rejected because of an overrun.
- R5: With `listen` = 0, a frame whose destination is neither accepted nor broadcast delivers no byte and never raises `ack_drive`.
- R6: With `listen` = 1, a frame whose destination is neither accepted nor broadcast is delivered, and `ack_drive` stays low throughout it.
- R7: `rx_end` is set in the same cycle as `rx_byte` for a block whose end-of-message bit is 1. A header with end-of-message 1 is a complete frame. Bits that arrive after the final block are ignored until the next start.
- R8: If a block completes while `rx_byte` is still set and not being cleared, `rx_ovr` is set and `rx_data` keeps the old byte. The rest of the frame is dropped. The slot of that block is not driven in a direct frame and is driven low in a broadcast frame.
- R9: `rx_ackerr` is set, and the frame is aborted, in two cases. The first is a listen frame whose slot samples 1, meaning nobody acknowledged. The second is a broadcast frame whose slot samples 0 when this block did not drive it, meaning another follower rejected it.
- R10: `start_det` restarts frame reception in every state and discards a partially shifted byte.
- R11: The flags stay set until a `flag_clr` pulse clears them. The bit mapping is: bit 0 clears `rx_byte`, bit 1 clears `rx_end`, bit 2 clears `rx_ovr`, and bit 3 clears `rx_ackerr`. A clear bit affects only its own flag.
- R12: A low `enable` drops `ack_drive` in the same cycle and abandons the frame. Bits that arrive afterwards are ignored until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable; low abandons the frame |
| start_det | input | 1 | Start bit detected (one-cycle pulse) |
| bit_valid | input | 1 | Sampled data bit is available (one-cycle pulse) |
| bit_val | input | 1 | Value of the sampled bit |
| own_mask | input | 15 | Accepted logical addresses, one bit per address 0..14 |
| listen | input | 1 | Deliver frames addressed to others without acknowledging them |
| flag_clr | input | 4 | Write-one-to-clear pulses for the four flags |
| ack_drive | output | 1 | Request to pull the acknowledge slot low |
| rx_data | output | 8 | Last delivered byte |
| rx_byte | output | 1 | Byte received flag |
| rx_end | output | 1 | End of reception flag |
| rx_ovr | output | 1 | Overrun flag |
| rx_ackerr | output | 1 | Missing acknowledge flag |

## Verification
A wrong frame mode shows up at the first acknowledge slot of a frame, within one cycle after the header's end-of-message bit. In that cycle `ack_drive` either rises for a frame that should be silent or stays low for an accepted one. The same mistake also shows up as a byte delivered or withheld in that cycle. A bit counter that slips, or a byte shifted in the wrong order, changes `rx_data` at the next delivery, where the scoreboard compares it. A state that fails to return to IDLE after the final block, an overrun or an abort shows up as a spurious `rx_byte` when the trailing block's end-of-message bit arrives.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_EOM,
        ST_ACK
    } rx_state_t;

    typedef enum logic [1:0] {
        MD_NONE,
        MD_DIRECT,
        MD_BCAST,
        MD_LISTEN
    } frame_mode_t;

endpackage

// File: rtl/cec_rx_shifter.sv
module cec_rx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] byte_o,
    output logic [DATA_W-1:0] next_o,
    output logic              last_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] cnt_q;

    assign next_o = {byte_o[DATA_W-2:0], bit_in};
    assign last_o = (cnt_q == CNT_W'(DATA_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_o <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            byte_o <= '0;
            cnt_q  <= '0;
        end else if (shift_en && cnt_q != CNT_W'(DATA_W)) begin
            byte_o <= next_o;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DATA_W)); // R1

endmodule

// File: rtl/cec_rx_addr_match.sv
module cec_rx_addr_match
    import cec_rx_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [2*ADDR_W-1:0]      hdr,
    input  logic [(1<<ADDR_W)-2:0]   mask,
    input  logic                     listen,
    output frame_mode_t              mode
);
    localparam int NUM_OWN = (1 << ADDR_W) - 1;

    logic [ADDR_W-1:0]  dest;
    logic [NUM_OWN-1:0] hit_vec;
    logic               hit;
    logic               bcast;

    assign dest  = hdr[ADDR_W-1:0];
    assign bcast = (dest == {ADDR_W{1'b1}});

    for (genvar g = 0; g < NUM_OWN; g++) begin : g_addr
        assign hit_vec[g] = mask[g] && (dest == ADDR_W'(g));
    end

    assign hit = |hit_vec;

    always_comb begin
        if (bcast)       mode = MD_BCAST;
        else if (hit)    mode = MD_DIRECT;
        else if (listen) mode = MD_LISTEN;
        else             mode = MD_NONE;
    end

    always_comb begin
        AST_ONE_HIT: assert ($onehot0(hit_vec)); // R2
    end

endmodule

// File: rtl/cec_rx_status.sv
module cec_rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deliver,
    input  logic              deliver_eom,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              ovr_set,
    input  logic              ackerr_set,
    input  logic [3:0]        clr,
    output logic [DATA_W-1:0] data_o,
    output logic              byte_f,
    output logic              end_f,
    output logic              ovr_f,
    output logic              ackerr_f
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o   <= '0;
            byte_f   <= 1'b0;
            end_f    <= 1'b0;
            ovr_f    <= 1'b0;
            ackerr_f <= 1'b0;
        end else begin
            if (deliver) data_o <= byte_in;
            byte_f   <= (byte_f   & ~clr[0]) | deliver;
            end_f    <= (end_f    & ~clr[1]) | (deliver & deliver_eom);
            ovr_f    <= (ovr_f    & ~clr[2]) | ovr_set;
            ackerr_f <= (ackerr_f & ~clr[3]) | ackerr_set;
        end
    end

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_f) |-> $stable(data_o)); // R8
    AST_BYTE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_f && !clr[0]) |=> byte_f); // R11

endmodule

// File: rtl/cec_frame_rx.sv
module cec_frame_rx
    import cec_rx_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic                        start_det,
    input  logic                        bit_valid,
    input  logic                        bit_val,
    input  logic [(1<<ADDR_W)-2:0]      own_mask,
    input  logic                        listen,
    input  logic [3:0]                  flag_clr,
    output logic                        ack_drive,
    output logic [2*ADDR_W-1:0]         rx_data,
    output logic                        rx_byte,
    output logic                        rx_end,
    output logic                        rx_ovr,
    output logic                        rx_ackerr
);
    localparam int DATA_W = 2 * ADDR_W;

    rx_state_t   state_q, state_d;
    frame_mode_t mode_q, mode_d, match_mode;
    logic hdr_q, hdr_d;
    logic eom_q, eom_d;
    logic drive_q, drive_d;
    logic stop_q, stop_d;

    logic              shift_clr, shift_en, shift_last;
    logic [DATA_W-1:0] shift_byte, shift_next;
    logic              deliver, ovr_set, ackerr_set;

    cec_rx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (shift_clr),
        .shift_en (shift_en),
        .bit_in   (bit_val),
        .byte_o   (shift_byte),
        .next_o   (shift_next),
        .last_o   (shift_last)
    );

    cec_rx_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .hdr    (shift_next),
        .mask   (own_mask),
        .listen (listen),
        .mode   (match_mode)
    );

    cec_rx_status #(.DATA_W(DATA_W)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .deliver     (deliver),
        .deliver_eom (bit_val),
        .byte_in     (shift_byte),
        .ovr_set     (ovr_set),
        .ackerr_set  (ackerr_set),
        .clr         (flag_clr),
        .data_o      (rx_data),
        .byte_f      (rx_byte),
        .end_f       (rx_end),
        .ovr_f       (rx_ovr),
        .ackerr_f    (rx_ackerr)
    );

    // next-state and control
    always_comb begin
        state_d    = state_q;
        mode_d     = mode_q;
        hdr_d      = hdr_q;
        eom_d      = eom_q;
        drive_d    = drive_q;
        stop_d     = stop_q;
        shift_clr  = !enable;
        shift_en   = 1'b0;
        deliver    = 1'b0;
        ovr_set    = 1'b0;
        ackerr_set = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;
            mode_d  = MD_NONE;
            drive_d = 1'b0;
            stop_d  = 1'b0;
        end else if (start_det) begin
            state_d   = ST_DATA;
            mode_d    = MD_NONE;
            hdr_d     = 1'b1;
            eom_d     = 1'b0;
            drive_d   = 1'b0;
            stop_d    = 1'b0;
            shift_clr = 1'b1;
        end else if (bit_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_DATA: begin
                    shift_en = 1'b1;
                    if (shift_last) begin
                        if (hdr_q) begin
                            mode_d  = match_mode;
                            state_d = (match_mode == MD_NONE) ? ST_IDLE : ST_EOM;
                        end else begin
                            state_d = ST_EOM;
                        end
                    end
                end
                ST_EOM: begin
                    eom_d   = bit_val;
                    state_d = ST_ACK;
                    if (rx_byte && !flag_clr[0]) begin
                        ovr_set = 1'b1;
                        stop_d  = 1'b1;
                        drive_d = (mode_q == MD_BCAST);
                    end else begin
                        deliver = 1'b1;
                        drive_d = (mode_q == MD_DIRECT);
                    end
                end
                ST_ACK: begin
                    hdr_d     = 1'b0;
                    drive_d   = 1'b0;
                    shift_clr = 1'b1;
                    if (!stop_q && ((mode_q == MD_LISTEN && bit_val) ||
                                    (mode_q == MD_BCAST && !bit_val))) begin
                        ackerr_set = 1'b1;
                        state_d    = ST_IDLE;
                    end else if (stop_q || eom_q) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_DATA;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MD_NONE;
            hdr_q   <= 1'b0;
            eom_q   <= 1'b0;
            drive_q <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            hdr_q   <= hdr_d;
            eom_q   <= eom_d;
            drive_q <= drive_d;
            stop_q  <= stop_d;
        end
    end

    // outputs
    always_comb begin
        ack_drive = enable && drive_q && (state_q == ST_ACK);
    end

    AST_END_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_end) |-> rx_byte); // R7
    AST_NO_ACK_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_LISTEN) |-> !ack_drive); // R6
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ST_IDLE && !ack_drive)); // R12
    AST_ACK_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_drive && bit_valid && !start_det) |=> !ack_drive); // R3

endmodule

// File: tb/cec_frame_rx_bench.sv
module cec_frame_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        start_det = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_val = 1'b0;
    logic [14:0] own_mask = 15'h0021;
    logic        listen = 1'b0;
    logic [3:0]  flag_clr = 4'h0;
    logic        ack_drive;
    logic [7:0]  rx_data;
    logic        rx_byte, rx_end, rx_ovr, rx_ackerr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [8:0] exp_q[$];
    logic prev_byte = 1'b0;

    always #10 clk = ~clk;

    cec_frame_rx u_cec_frame_rx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_det(start_det),
        .bit_valid(bit_valid), .bit_val(bit_val), .own_mask(own_mask),
        .listen(listen), .flag_clr(flag_clr), .ack_drive(ack_drive),
        .rx_data(rx_data), .rx_byte(rx_byte), .rx_end(rx_end),
        .rx_ovr(rx_ovr), .rx_ackerr(rx_ackerr)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare each newly delivered byte with the scoreboard
    always @(negedge clk) begin
        if (rst_n && rx_byte && !prev_byte) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected delivery", {23'd0, rx_end, rx_data}, 32'h1ff);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk("R1 R7 delivered byte/end", {23'd0, rx_end, rx_data}, {23'd0, e});
            end
        end
        prev_byte <= rx_byte;
    end

    task automatic send_bit(logic v);
        bit_val = v; bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic start();
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
        @(negedge clk);
    endtask

    task automatic clr(logic [3:0] m);
        flag_clr = m;
        @(negedge clk);
        flag_clr = 4'h0;
        @(negedge clk);
    endtask

    task automatic expect_byte(logic [7:0] b, logic eom);
        exp_q.push_back({eom, b});
    endtask

    task automatic send_block(logic [7:0] b, logic eom, logic slot, logic exp_ack, string req);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(eom);
        chk(req, {31'd0, ack_drive}, {31'd0, exp_ack});
        send_bit(slot);
        chk({req, " released"}, {31'd0, ack_drive}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; enable = 1'b1;
        @(negedge clk);
        chk("R11 reset flags", {28'd0, rx_byte, rx_end, rx_ovr, rx_ackerr}, 32'd0);
        chk("R3 reset ack", {31'd0, ack_drive}, 32'd0);

        // R3 direct frame to 5, three blocks
        start();
        expect_byte(8'h45, 0); send_block(8'h45, 0, 0, 1, "R3 header ack"); clr(4'h3);
        expect_byte(8'h36, 0); send_block(8'h36, 0, 0, 1, "R3 opcode ack"); clr(4'h3);
        expect_byte(8'hA1, 1); send_block(8'hA1, 1, 0, 1, "R3 last ack");
        chk("R7 end flag", {31'd0, rx_end}, 32'd1);
        clr(4'h3);

        // R7 ping to address 0, then trailing block ignored
        start();
        expect_byte(8'h30, 1); send_block(8'h30, 1, 0, 1, "R7 ping ack"); clr(4'h3);
        send_block(8'h12, 0, 1, 0, "R7 trailing no ack");
        chk("R7 trailing ignored", {31'd0, rx_byte}, 32'd0);

        // R2 address 14 via mask bit 14
        own_mask = 15'h4000;
        start();
        expect_byte(8'h2E, 1); send_block(8'h2E, 1, 0, 1, "R2 addr14 ack"); clr(4'h3);
        start();
        send_block(8'h25, 1, 1, 0, "R2 addr5 not accepted");
        chk("R2 addr5 dropped", {31'd0, rx_byte}, 32'd0);
        own_mask = 15'h0021;

        // R4 broadcast accepted
        start();
        expect_byte(8'h4F, 0); send_block(8'h4F, 0, 1, 0, "R4 bcast no drive"); clr(4'h3);
        expect_byte(8'h55, 1); send_block(8'h55, 1, 1, 0, "R4 bcast last"); clr(4'h3);
        chk("R4 no ackerr", {31'd0, rx_ackerr}, 32'd0);

        // R5 non-matching, listen off
        start();
        send_block(8'h43, 0, 0, 0, "R5 no ack");
        send_block(8'h11, 1, 0, 0, "R5 no ack body");
        chk("R5 nothing delivered", {31'd0, rx_byte}, 32'd0);

        // R6 listen mode
        listen = 1'b1;
        start();
        expect_byte(8'h43, 0); send_block(8'h43, 0, 0, 0, "R6 listen silent"); clr(4'h3);
        expect_byte(8'h11, 1); send_block(8'h11, 1, 0, 0, "R6 listen silent last"); clr(4'h3);
        chk("R6 no ackerr when acked", {31'd0, rx_ackerr}, 32'd0);

        // R9 listen, nobody acknowledges
        start();
        expect_byte(8'h47, 0); send_block(8'h47, 0, 1, 0, "R9 listen slot"); clr(4'h3);
        chk("R9 listen ackerr", {31'd0, rx_ackerr}, 32'd1);
        send_block(8'h22, 1, 0, 0, "R9 aborted block");
        chk("R9 aborted not delivered", {31'd0, rx_byte}, 32'd0);
        clr(4'h8);
        listen = 1'b0;

        // R9 broadcast rejected by another follower
        start();
        expect_byte(8'h1F, 0); send_block(8'h1F, 0, 0, 0, "R9 bcast slot"); clr(4'h3);
        chk("R9 bcast ackerr", {31'd0, rx_ackerr}, 32'd1);
        clr(4'h8);

        // R8 overrun in direct frame
        start();
        expect_byte(8'h05, 0); send_block(8'h05, 0, 0, 1, "R8 first ack");
        send_block(8'h66, 0, 0, 0, "R8 direct overrun no ack");
        chk("R8 ovr flag", {31'd0, rx_ovr}, 32'd1);
        chk("R8 data kept", {24'd0, rx_data}, 32'h05);
        clr(4'h1);
        send_block(8'h77, 1, 0, 0, "R8 after overrun ignored");
        chk("R8 rest dropped", {31'd0, rx_byte}, 32'd0);
        clr(4'hF);

        // R8 overrun in broadcast frame: reject
        start();
        expect_byte(8'h0F, 0); send_block(8'h0F, 0, 1, 0, "R8 bcast first");
        send_block(8'h77, 0, 0, 1, "R8 bcast overrun rejects");
        chk("R8 bcast ovr", {31'd0, rx_ovr}, 32'd1);
        clr(4'hF);

        // R10 start mid-byte discards partial
        start();
        send_bit(1); send_bit(1); send_bit(1);
        start();
        expect_byte(8'h45, 1); send_block(8'h45, 1, 0, 1, "R10 restart ack");

        // R11 sticky and independent clears
        repeat (5) @(negedge clk);
        chk("R11 byte sticky", {31'd0, rx_byte}, 32'd1);
        clr(4'h2);
        chk("R11 end cleared", {31'd0, rx_end}, 32'd0);
        chk("R11 byte untouched", {31'd0, rx_byte}, 32'd1);
        clr(4'h1);

        // R12 disable in acknowledge slot
        start();
        expect_byte(8'h45, 0);
        for (int i = 7; i >= 0; i--) send_bit(8'h45 >> i);
        send_bit(0);
        chk("R12 ack before disable", {31'd0, ack_drive}, 32'd1);
        enable = 1'b0;
        #1;
        chk("R12 ack released", {31'd0, ack_drive}, 32'd0);
        @(negedge clk);
        enable = 1'b1;
        clr(4'h3);
        send_bit(0);
        send_block(8'h45, 1, 0, 0, "R12 no ack after disable");
        chk("R12 ignored after disable", {31'd0, rx_byte}, 32'd0);

        repeat (4) @(negedge clk);
        chk("R1 scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule